// File: doc/BRIEF.md
# Serial Transmitter with Graceful Disable

This block serialises characters onto a transmit pin. It has a one-character holding register that feeds a shift register. Each frame has one start bit at 0, the data bits sent least significant bit first, and a stop field at 1. Every bit lasts one period of an external bit-rate tick. Software writes characters through a data-write strobe. It controls the block with three level inputs: an enable, a mask for the "holding register empty" flag, and a mask for the "transmission complete" flag. The interrupt request output is the masked OR of the two flags.

The pin is shared with a general-purpose output. While the transmitter is enabled it owns the pin and drives it high between frames. Clearing the enable does not cut a frame short. A character that is already shifting completes. A character that is only waiting in the holding register is discarded. The pin goes back to the general-purpose value on a bit-tick boundary, and both flags set when the last frame ends, even though the enable is off. Only the reset stops a frame in the middle of a bit.

Top module: `txg_top`

## Requirements
- R1: During and after reset, with no enable, the empty flag and the complete flag are 0, the interrupt request is 0, and the pin follows the general-purpose output value.
- R2: In the cycle after the enable rises from 0 to 1, the empty flag is 1. The complete flag is also 1 unless a frame is still shifting from before.
- R3: A write strobe while enabled stores the data and clears both flags in the next cycle. A write strobe while disabled is ignored: the flags do not change and no frame starts.
- R4: A bit tick moves a waiting character into the shifter when the shifter is idle. The same happens on the tick that ends the previous frame, so frames run back to back. The empty flag sets in the following cycle.
- R5: While the transmitter owns the pin, an idle pin is 1. A frame drives the start bit 0 after its loading tick, then each data bit LSB first after each following tick, then the stop bits at 1.
- R6: The tick that ends a frame, with no character waiting, sets the complete flag. The complete flag is never 1 while the empty flag is 0.
- R7: The interrupt request is 1 exactly when (empty flag AND its mask) OR (complete flag AND its mask).
- R8: Clearing the enable during a frame lets that frame finish bit for bit and discards a waiting character. Both flags set when the frame ends.
- R9: With the enable clear, the pin returns to the general-purpose value in the cycle after the first bit tick at which the shifter is idle or ends its frame. Before that tick the pin stays under transmitter control.
- R10: Asserting reset in the middle of a frame stops it at once: the pin follows the general-purpose value and both flags read 0.
- R11: A second write before the waiting character has been loaded overwrites it, so only the last value written is sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| te | input | 1 | Transmitter enable (level) |
| tie | input | 1 | Mask for the empty-flag interrupt |
| tcie | input | 1 | Mask for the complete-flag interrupt |
| wr_data | input | 1 | Data register write strobe |
| wdata | input | DATA_W | Character to send |
| gpio_out | input | 1 | General-purpose value for the pin |
| txd | output | 1 | Serial pin |
| tdre | output | 1 | Holding register empty flag |
| tc | output | 1 | Transmission complete flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench uses the default eight data bits and one stop bit, so a frame takes ten bit periods. It drives the tick at short, irregular intervals, which keeps hundreds of complete frames within the cycle budget. At the same time, the random enable toggles, back-to-back writes and overwrites, mask changes and occasional mid-frame resets often land on the frame-ending tick itself. Directed cases pin down the cycles that matter most: graceful shutdown with a queued character, disabling while idle before and after a tick, and a reset in the middle of a bit.

// File: rtl/txg_pkg.sv
package txg_pkg;

    typedef enum logic {
        OWN_GPIO   = 1'b0,
        OWN_SERIAL = 1'b1
    } owner_e;

    localparam logic START_LEVEL = 1'b0;
    localparam logic STOP_LEVEL  = 1'b1;
    localparam logic IDLE_LEVEL  = 1'b1;

    function automatic int unsigned frame_bits(input int unsigned data_w,
                                               input int unsigned stop_w);
        return 1 + data_w + stop_w;
    endfunction

endpackage

// File: rtl/txg_ctrl.sv
module txg_ctrl #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              te,
    input  logic              wr_data,
    input  logic [DATA_W-1:0] wdata,
    input  logic              load,
    input  logic              done,
    input  logic              pin_free,
    input  logic              busy,
    output logic              hold_full,
    output logic [DATA_W-1:0] hold_data,
    output logic              te_rise,
    output logic              tdre,
    output logic              tc
);

    typedef struct packed {
        logic              te_prev;
        logic              hold_full;
        logic [DATA_W-1:0] hold_data;
        logic              tdre;
        logic              tc;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     wr_ok;

    assign wr_ok   = wr_data & te;
    assign te_rise = te & ~st_q.te_prev;

    always_comb begin
        st_d         = st_q;
        st_d.te_prev = te;

        // Waiting character: dropped when disabled, taken by the shifter on load
        if (!te) begin
            st_d.hold_full = 1'b0;
        end else if (wr_ok) begin
            st_d.hold_full = 1'b1;
        end else if (load) begin
            st_d.hold_full = 1'b0;
        end

        if (wr_ok) begin
            st_d.hold_data = wdata;
        end

        // Flag sets
        if (load || done || pin_free || te_rise) begin
            st_d.tdre = 1'b1;
        end
        if ((done && !load) || pin_free || (te_rise && !busy)) begin
            st_d.tc = 1'b1;
        end

        // A write wins over any set in the same cycle
        if (wr_ok) begin
            st_d.tdre = 1'b0;
            st_d.tc   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_full = st_q.hold_full;
    assign hold_data = st_q.hold_data;
    assign tdre      = st_q.tdre;
    assign tc        = st_q.tc;

endmodule

// File: rtl/txg_shifter.sv
module txg_shifter
    import txg_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned STOP_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              te,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    output logic              load,
    output logic              done,
    output logic              busy,
    output logic              line
);

    localparam int unsigned FRAME_W = frame_bits(DATA_W, STOP_W);
    localparam int unsigned CNT_W   = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        logic               busy;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] sh;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic      last;

    assign last = st_q.busy && (st_q.cnt == LAST_IDX);
    assign done = bit_tick && last;
    assign load = bit_tick && hold_full && te && (!st_q.busy || last);

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            st_d.sh   = {{STOP_W{STOP_LEVEL}}, hold_data, START_LEVEL};
        end else if (done) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
            st_d.sh   = '1;
        end else if (bit_tick && st_q.busy) begin
            st_d.cnt  = st_q.cnt + 1'b1;
            st_d.sh   = {IDLE_LEVEL, st_q.sh[FRAME_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, cnt: '0, sh: '1};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = st_q.busy;
    assign line = st_q.busy ? st_q.sh[0] : IDLE_LEVEL;

endmodule

// File: rtl/txg_pin.sv
module txg_pin
    import txg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic te,
    input  logic busy,
    input  logic done,
    input  logic line,
    input  logic gpio_out,
    output logic own,
    output logic pin_free,
    output logic txd
);

    owner_e own_d, own_q;

    assign pin_free = bit_tick && !te && (own_q == OWN_SERIAL) && (!busy || done);

    always_comb begin
        own_d = own_q;
        if (te) begin
            own_d = OWN_SERIAL;
        end else if (pin_free) begin
            own_d = OWN_GPIO;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            own_q <= OWN_GPIO;
        end else begin
            own_q <= own_d;
        end
    end

    assign own = (own_q == OWN_SERIAL);
    assign txd = own ? line : gpio_out;

endmodule

// File: rtl/txg_top.sv
module txg_top #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned STOP_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              te,
    input  logic              tie,
    input  logic              tcie,
    input  logic              wr_data,
    input  logic [DATA_W-1:0] wdata,
    input  logic              gpio_out,
    output logic              txd,
    output logic              tdre,
    output logic              tc,
    output logic              irq
);

    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic              load, done, busy, line;
    logic              own, pin_free, te_rise;

    txg_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .te        (te),
        .wr_data   (wr_data),
        .wdata     (wdata),
        .load      (load),
        .done      (done),
        .pin_free  (pin_free),
        .busy      (busy),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .te_rise   (te_rise),
        .tdre      (tdre),
        .tc        (tc)
    );

    txg_shifter #(.DATA_W(DATA_W), .STOP_W(STOP_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .te        (te),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .load      (load),
        .done      (done),
        .busy      (busy),
        .line      (line)
    );

    txg_pin u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_tick (bit_tick),
        .te       (te),
        .busy     (busy),
        .done     (done),
        .line     (line),
        .gpio_out (gpio_out),
        .own      (own),
        .pin_free (pin_free),
        .txd      (txd)
    );

    assign irq = (tdre & tie) | (tc & tcie);

endmodule

// File: rtl/txg_checker.sv
module txg_checker (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic te,
    input logic wr_data,
    input logic txd,
    input logic tdre,
    input logic tc,
    input logic busy,
    input logic own,
    input logic done,
    input logic te_rise
);

    p_enable_sets_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (te_rise && !wr_data) |=> tdre);

    p_write_clears_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && te) |=> (!tdre && !tc));

    p_frame_starts_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (txd == 1'b0));

    p_idle_line_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (own && !busy) |-> txd);

    p_complete_implies_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> tdre);

    p_frame_not_cut_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(bit_tick));

    p_flags_after_last_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !te && !wr_data) |=> (tdre && tc));

    p_release_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(own) |-> ($past(bit_tick) && !$past(te)));

endmodule

bind txg_top txg_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_tick (bit_tick),
    .te       (te),
    .wr_data  (wr_data),
    .txd      (txd),
    .tdre     (tdre),
    .tc       (tc),
    .busy     (busy),
    .own      (own),
    .done     (done),
    .te_rise  (te_rise)
);

// File: tb/txg_top_bench.sv
module txg_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 8;
    localparam int STOP_W     = 1;
    localparam int FRAME      = 1 + DATA_W + STOP_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bit_tick = 1'b0, te = 1'b0, tie = 1'b0, tcie = 1'b0;
    logic              wr_data = 1'b0, gpio_out = 1'b0;
    logic [DATA_W-1:0] wdata = '0;
    logic              txd, tdre, tc, irq;

    int n_checks = 0;
    int n_fail   = 0;

    txg_top #(.DATA_W(DATA_W), .STOP_W(STOP_W)) u_txg_top (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .te(te), .tie(tie),
        .tcie(tcie), .wr_data(wr_data), .wdata(wdata), .gpio_out(gpio_out),
        .txd(txd), .tdre(tdre), .tc(tc), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model, stepped on every rising edge ----------------
    bit                m_te_prev, m_hold_full, m_tdre, m_tc, m_busy, m_own;
    logic [DATA_W-1:0] m_hold, m_frame;
    int                m_cnt;

    function automatic logic frame_bit(input logic [DATA_W-1:0] d, input int k);
        if (k == 0) return 1'b0;
        if (k <= DATA_W) return d[k-1];
        return 1'b1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_te_prev = 0; m_hold_full = 0; m_tdre = 0; m_tc = 0;
            m_busy = 0; m_own = 0; m_hold = '0; m_frame = '0; m_cnt = 0;
        end else begin
            bit rise, wr, last, ld, dn, fr;
            rise = te && !m_te_prev;
            wr   = wr_data && te;
            last = m_busy && (m_cnt == FRAME - 1);
            ld   = bit_tick && m_hold_full && te && (!m_busy || last);
            dn   = bit_tick && last;
            fr   = bit_tick && !te && m_own && (!m_busy || dn);
            if ((ld || dn || fr || rise) && !wr) m_tdre = 1;
            if (((dn && !ld) || fr || (rise && !m_busy)) && !wr) m_tc = 1;
            if (wr) begin m_tdre = 0; m_tc = 0; end
            if (ld) begin m_busy = 1; m_cnt = 0; m_frame = m_hold; end
            else if (dn) begin m_busy = 0; m_cnt = 0; end
            else if (bit_tick && m_busy) m_cnt++;
            if (!te) m_hold_full = 0;
            else if (wr) m_hold_full = 1;
            else if (ld) m_hold_full = 0;
            if (wr) m_hold = wdata;
            if (te) m_own = 1; else if (fr) m_own = 0;
            m_te_prev = te;
        end
    end

    task automatic compare_model();
        logic exp_txd;
        exp_txd = m_own ? (m_busy ? frame_bit(m_frame, m_cnt) : 1'b1) : gpio_out;
        check(txd == exp_txd, m_own ? "R5 txd" : "R9 txd", 32'(txd), 32'(exp_txd));
        check(tdre == m_tdre, "R4 tdre", 32'(tdre), 32'(m_tdre));
        check(tc == m_tc, "R6 tc", 32'(tc), 32'(m_tc));
        check(irq == ((m_tdre && tie) || (m_tc && tcie)), "R7 irq", 32'(irq),
              32'((m_tdre && tie) || (m_tc && tcie)));
    endtask

    task automatic cyc();
        @(negedge clk);
        compare_model();
    endtask

    task automatic tick_sample(output logic v);
        cyc(); bit_tick = 1'b1;
        cyc(); bit_tick = 1'b0; v = txd;
        cyc(); cyc();
    endtask

    task automatic write(input logic [DATA_W-1:0] d);
        cyc(); wr_data = 1'b1; wdata = d;
        cyc(); wr_data = 1'b0;
    endtask

    // send remaining frame bits 1..FRAME-1 and compare against d
    task automatic rest_of_frame(input logic [DATA_W-1:0] d, input int from, input string tag);
        int bad = 0;
        logic v;
        for (int k = from; k < FRAME; k++) begin
            tick_sample(v);
            if (v !== frame_bit(d, k)) bad++;
        end
        check(bad == 0, tag, 32'(bad), 0);
    endtask

    // watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic v;
        int   bad;
        void'($urandom(32'h5eed_0c11));

        // R1: reset state
        tie = 1; tcie = 1; gpio_out = 1;
        repeat (3) @(negedge clk);
        check(tdre == 0 && tc == 0, "R1 flags in reset", {tdre, tc}, 0);
        check(irq == 0, "R1 irq in reset", 32'(irq), 0);
        check(txd == 1, "R1 pin follows gpio", 32'(txd), 1);
        gpio_out = 0; #1;
        check(txd == 0, "R1 pin follows gpio low", 32'(txd), 0);
        @(negedge clk); rst_n = 1;
        cyc();

        // R3: write while disabled is ignored
        write(8'h3C);
        check(tdre == 0 && tc == 0, "R3 write disabled keeps flags", {tdre, tc}, 0);
        tick_sample(v);
        check(v == 0, "R3 no frame while disabled", 32'(v), 0);

        // R2: enable sets both flags
        cyc(); te = 1;
        cyc();
        check(tdre == 1 && tc == 1, "R2 enable sets flags", {tdre, tc}, 32'h3);
        check(irq == 1, "R7 irq with masks set", 32'(irq), 1);
        tie = 0; tcie = 0; cyc();
        check(irq == 0, "R7 irq masked", 32'(irq), 0);

        // R3, R4, R5, R6: single frame
        write(8'hA5);
        check(tdre == 0 && tc == 0, "R3 write clears flags", {tdre, tc}, 0);
        tick_sample(v);
        check(v == 0, "R5 start bit", 32'(v), 0);
        check(tdre == 1 && tc == 0, "R4 load sets empty only", {tdre, tc}, 32'h2);
        rest_of_frame(8'hA5, 1, "R5 frame bits A5");
        tick_sample(v);
        check(tdre == 1 && tc == 1, "R6 complete after frame", {tdre, tc}, 32'h3);
        check(v == 1, "R5 idle high after frame", 32'(v), 1);

        // R4 back to back, R11 overwrite
        write(8'h81);
        tick_sample(v);
        write(8'h11);
        write(8'h6E);
        rest_of_frame(8'h81, 1, "R5 frame bits 81");
        tick_sample(v);
        check(v == 0 && tc == 0, "R4 back-to-back start", {v, tc}, 0);
        rest_of_frame(8'h6E, 1, "R11 last write sent");
        tick_sample(v);
        check(tc == 1 && v == 1, "R6 complete after second frame", {tc, v}, 32'h3);

        // R8, R9: graceful disable with a queued character
        gpio_out = 0;
        write(8'hC3);
        tick_sample(v);
        write(8'h5A);
        bad = 0;
        for (int k = 1; k <= 3; k++) begin
            tick_sample(v);
            if (v !== frame_bit(8'hC3, k)) bad++;
        end
        cyc(); te = 0;
        cyc();
        check(tdre == 0 && tc == 0, "R8 flags wait for frame end", {tdre, tc}, 0);
        for (int k = 4; k < FRAME; k++) begin
            tick_sample(v);
            if (v !== frame_bit(8'hC3, k)) bad++;
        end
        check(bad == 0, "R8 frame completes after disable", 32'(bad), 0);
        tick_sample(v);
        check(tdre == 1 && tc == 1, "R8 flags set after disable", {tdre, tc}, 32'h3);
        check(v == 0, "R9 pin released to gpio", 32'(v), 0);
        bad = 0;
        for (int k = 0; k < FRAME + 2; k++) begin
            tick_sample(v);
            if (v !== 1'b0) bad++;
        end
        check(bad == 0, "R8 queued character dropped", 32'(bad), 0);

        // R9: disable while idle waits for a tick
        cyc(); te = 1;
        repeat (3) cyc();
        te = 0;
        repeat (3) cyc();
        check(txd == 1, "R9 pin held until tick", 32'(txd), 1);
        tick_sample(v);
        check(v == 0, "R9 pin free after tick", 32'(v), 0);

        // R10: reset in the middle of a frame
        cyc(); te = 1; gpio_out = 1;
        write(8'h00);
        tick_sample(v);
        tick_sample(v);
        check(txd == 0, "R5 data zero on line", 32'(txd), 0);
        rst_n = 0; #1;
        check(txd == 1 && tdre == 0 && tc == 0, "R10 reset stops frame",
              {txd, tdre, tc}, 32'h4);
        @(negedge clk); rst_n = 1; te = 0;
        cyc();

        // random phase
        for (int i = 0; i < 60000; i++) begin
            cyc();
            bit_tick = ($urandom % 3) == 0;
            if (($urandom % 80) == 0) te = ~te;
            if (($urandom % 16) == 0) begin tie = $urandom; tcie = $urandom; end
            wr_data = ($urandom % 9) == 0;
            wdata   = DATA_W'($urandom);
            if (($urandom % 7) == 0) gpio_out = $urandom;
            if (($urandom % 4000) == 0) begin
                rst_n = 0;
                cyc(); cyc();
                rst_n = 1;
            end
        end
        cyc();

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule